// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

The block sits beside a system bus and times every access that it is asked to watch. A cycle-start strobe opens a timing window and clears the wait count. Each following clock edge without a termination acknowledge adds one waiting cycle. If the number of waiting cycles reaches the programmed limit before any acknowledge, the block raises a one-cycle bus-error pulse and, in the same cycle, a forced-termination pulse. The bus controller uses that pulse to end the hanging access, so a read of an undecoded address or a write to a dead peripheral cannot stall the bus forever.

A 2-bit period select sets the limit, and the block latches it when the cycle starts. A scope bit chooses whether only internal cycles are watched or external cycles as well. While the debug-mode input is high, no cycle is watched. A 32-bit access to a 16-bit external port arrives as two start strobes, and each half gets its own full window. The block raises no interrupts. Its only error indication is the bus-error pulse.

Top module: `cycle_timeout_monitor`

## Requirements
- R1: The limit in waiting cycles is 8, 16, 32 or 64 for a select code of 00, 01, 10 or 11. If a watched cycle's start strobe is sampled at edge 0 and no acknowledge is sampled at edges 1 to N, bus_err_o is high for exactly the one cycle that follows edge N.
- R2: A start strobe sampled while a cycle is being timed discards the old window and opens a fresh one of the full length. No error follows the edge on which a start is sampled.
- R3: force_term_o pulses in exactly the same cycle as bus_err_o, and each pulse lasts a single cycle.
- R4: An acknowledge sampled on any edge from 1 to N ends the timing, and no error is raised for that cycle. This includes an acknowledge on edge N itself, the edge on which the timeout would otherwise fire.
- R5: With scope_ext_i = 0, a cycle whose cyc_ext_i is 1 is not timed and never produces an error. With scope_ext_i = 1, external cycles are timed like internal ones. Internal cycles are always timed.
- R6: A cycle whose start is sampled with dbg_mode_i = 1 is not timed. If dbg_mode_i is sampled high while a cycle is being timed, that cycle is abandoned without an error.
- R7: A 32-bit access to a 16-bit port is timed as two separate external cycles. The second start strobe opens a full new window, whatever time the first half took.
- R8: After a timeout the block stays idle and raises no further error until the next watched start strobe. An acknowledge while idle has no effect.
- R9: A synchronous active-low reset clears the count, abandons any cycle and holds both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start_i | input | 1 | One-cycle strobe that opens a bus cycle |
| term_ack_i | input | 1 | Termination acknowledge from the addressed target |
| cyc_ext_i | input | 1 | 1 = the starting cycle is external, 0 = internal |
| dbg_mode_i | input | 1 | Debug mode; suppresses all monitoring while high |
| period_sel_i | input | 2 | Timeout limit code: 00=8, 01=16, 10=32, 11=64 cycles |
| scope_ext_i | input | 1 | 0 = watch internal cycles only, 1 = watch internal and external |
| bus_err_o | output | 1 | One-cycle bus-error pulse on timeout |
| force_term_o | output | 1 | One-cycle pulse that forces the hanging cycle to end |

## Verification
The bench walks every select code and checks that the error appears one edge after the limit, not one edge before or after it. An off-by-one counter would fail this. It places an acknowledge exactly on the limit edge: a design that let the timeout win that race would flag a cycle that did complete. It restarts a window mid-count and times a split 16-bit access, which catches a counter that is not cleared on a new start. It also runs unwatched external cycles, debug-mode cycles and a mid-cycle reset, where any error pulse would mean the scope gating or the reset is wrong.

// File: rtl/cto_pkg.sv
// Package: shared sizing for the cycle timeout monitor.
// Assumes the limit doubles for each step of the select code, starting at BASE.
package cto_pkg;
    localparam int unsigned CTO_BASE_CYCLES = 8;
    localparam int unsigned CTO_SEL_W       = 2;

    // Largest limit reachable for a given base and select width.
    function automatic int unsigned cto_max_limit(input int unsigned base, input int unsigned sel_w);
        return base << ((1 << sel_w) - 1);
    endfunction
endpackage

// File: rtl/cto_limit_dec.sv
// Module: turns the period select code into a cycle limit.
// Assumes code k selects BASE_CYCLES << k; purely combinational.
module cto_limit_dec #(
    parameter int unsigned BASE_CYCLES = 8,
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned CNT_W       = 7
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] limit_o
);
    localparam int unsigned NUM_CODES = 1 << SEL_W;

    logic [CNT_W-1:0] limit_tab [NUM_CODES];

    // One table entry per select code, doubling at each step.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign limit_tab[g] = CNT_W'(BASE_CYCLES << g);
    end

    // Pick the entry for the current code.
    always_comb begin
        limit_o = limit_tab[sel_i];
    end
endmodule

// File: rtl/cto_scope_qual.sv
// Module: decides whether a starting cycle belongs to the watched class.
// Assumes cyc_ext_i is valid in the same cycle as the start strobe.
module cto_scope_qual (
    input  logic cyc_ext_i,
    input  logic scope_ext_i,
    input  logic dbg_mode_i,
    output logic watch_o
);
    // Internal cycles are always watched; external ones only when scope allows it; debug hides all.
    always_comb begin
        watch_o = !dbg_mode_i && (!cyc_ext_i || scope_ext_i);
    end
endmodule

// File: rtl/cto_wait_counter.sv
// Module: times one bus cycle and pulses on timeout.
// Assumes start has priority over acknowledge and abort; limit is latched at start.
module cto_wait_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             watch_i,
    input  logic             ack_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             tmo_o
);
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt_inc;

    // Next wait count if this edge passes without an acknowledge.
    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
    end

    // Window state: arm on start, count waits, disarm on ack, abort or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            limit_q <= '0;
            tmo_o   <= 1'b0;
        end else begin
            tmo_o <= 1'b0;
            if (start_i) begin
                armed_q <= watch_i;
                cnt_q   <= '0;
                limit_q <= limit_i;
            end else if (armed_q) begin
                if (ack_i || abort_i) begin
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                end else if (cnt_inc == limit_q) begin
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                    tmo_o   <= 1'b1;
                end else begin
                    cnt_q <= cnt_inc;
                end
            end
        end
    end
endmodule

// File: rtl/cycle_timeout_monitor.sv
// Module: bus cycle timeout monitor top level.
// Assumes one outstanding bus cycle at a time; a split access arrives as two starts.
module cycle_timeout_monitor #(
    parameter int unsigned BASE_CYCLES = cto_pkg::CTO_BASE_CYCLES,
    parameter int unsigned SEL_W       = cto_pkg::CTO_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start_i,
    input  logic             term_ack_i,
    input  logic             cyc_ext_i,
    input  logic             dbg_mode_i,
    input  logic [SEL_W-1:0] period_sel_i,
    input  logic             scope_ext_i,
    output logic             bus_err_o,
    output logic             force_term_o
);
    localparam int unsigned MAX_LIMIT = cto_pkg::cto_max_limit(BASE_CYCLES, SEL_W);
    localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

    logic [CNT_W-1:0] limit;
    logic             watch;
    logic             tmo;

    cto_limit_dec #(
        .BASE_CYCLES(BASE_CYCLES),
        .SEL_W      (SEL_W),
        .CNT_W      (CNT_W)
    ) u_limit (
        .sel_i  (period_sel_i),
        .limit_o(limit)
    );

    cto_scope_qual u_scope (
        .cyc_ext_i  (cyc_ext_i),
        .scope_ext_i(scope_ext_i),
        .dbg_mode_i (dbg_mode_i),
        .watch_o    (watch)
    );

    cto_wait_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(cyc_start_i),
        .watch_i(watch),
        .ack_i  (term_ack_i),
        .abort_i(dbg_mode_i),
        .limit_i(limit),
        .tmo_o  (tmo)
    );

    // Both outputs carry the same timeout pulse.
    always_comb begin
        bus_err_o    = tmo;
        force_term_o = tmo;
    end
endmodule

// File: rtl/cycle_timeout_monitor_chk.sv
// Checker: temporal properties of the timeout monitor, bound to the top.
// Assumes the default two-bit select.
module cycle_timeout_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_start_i,
    input logic term_ack_i,
    input logic cyc_ext_i,
    input logic dbg_mode_i,
    input logic scope_ext_i,
    input logic bus_err_o,
    input logic force_term_o
);
    logic unwatched_q;

    // Tracks that the most recent start was outside the watched class.
    always_ff @(posedge clk) begin
        if (!rst_n) unwatched_q <= 1'b0;
        else if (cyc_start_i) unwatched_q <= dbg_mode_i || (cyc_ext_i && !scope_ext_i);
    end

    a_r3_err_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |=> !bus_err_o);
    a_r3_force_tracks_err: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o == force_term_o);
    a_r4_ack_blocks_err: assert property (@(posedge clk) disable iff (!rst_n)
        term_ack_i |=> !bus_err_o);
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_i |=> !bus_err_o);
    a_r6_debug_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_i |=> !bus_err_o);
    a_r5_unwatched_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(unwatched_q && bus_err_o));
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!bus_err_o && !force_term_o));
endmodule

bind cycle_timeout_monitor cycle_timeout_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .term_ack_i  (term_ack_i),
    .cyc_ext_i   (cyc_ext_i),
    .dbg_mode_i  (dbg_mode_i),
    .scope_ext_i (scope_ext_i),
    .bus_err_o   (bus_err_o),
    .force_term_o(force_term_o)
);

// File: tb/cycle_timeout_monitor_bench.sv
module cycle_timeout_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start_i = 1'b0;
    logic       term_ack_i = 1'b0;
    logic       cyc_ext_i = 1'b0;
    logic       dbg_mode_i = 1'b0;
    logic [1:0] period_sel_i = 2'b00;
    logic       scope_ext_i = 1'b0;
    logic       bus_err_o;
    logic       force_term_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cycle_timeout_monitor u_cycle_timeout_monitor (
        .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start_i), .term_ack_i(term_ack_i),
        .cyc_ext_i(cyc_ext_i), .dbg_mode_i(dbg_mode_i), .period_sel_i(period_sel_i),
        .scope_ext_i(scope_ext_i), .bus_err_o(bus_err_o), .force_term_o(force_term_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse a start at the current negedge, then observe edges 1..total.
    // Error expected only after edge err_at (0 = never); ack driven for edge ack_at,
    // a second start for edge restart_at, debug for edge dbg_at (0 = none).
    task automatic run_window(input bit ext, input int total, input int err_at,
                              input int ack_at, input int restart_at, input int dbg_at,
                              input string req);
        int bad_k = -1;
        int bad_v = 0;
        cyc_ext_i   = ext;
        cyc_start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int k = 1; k <= total + 1; k++) begin
            cyc_start_i = (k == restart_at);
            term_ack_i  = (k == ack_at);
            dbg_mode_i  = (k == dbg_at);
            @(negedge clk);
            if (k <= total && bad_k < 0 &&
                ((bus_err_o != (k == err_at)) || (force_term_o != bus_err_o))) begin
                bad_k = k;
                bad_v = {bus_err_o, force_term_o};
            end
        end
        cyc_start_i = 1'b0;
        term_ack_i  = 1'b0;
        dbg_mode_i  = 1'b0;
        check(bad_k < 0, req, bad_v, (bad_k == err_at) ? 3 : 0);
    endtask

    task automatic t_reset();
        check(bus_err_o == 1'b0, "R9 reset err", bus_err_o, 0);
        check(force_term_o == 1'b0, "R9 reset force", force_term_o, 0);
    endtask

    task automatic t_periods();
        for (int s = 0; s < 4; s++) begin
            period_sel_i = 2'(s);
            run_window(1'b0, (8 << s) + 4, 8 << s, 0, 0, 0, "R1 R3 timeout at limit");
        end
    endtask

    task automatic t_ack();
        period_sel_i = 2'b01;
        run_window(1'b0, 24, 0, 5, 0, 0, "R4 early ack");
        run_window(1'b0, 24, 0, 16, 0, 0, "R4 ack on limit edge");
    endtask

    task automatic t_restart();
        period_sel_i = 2'b00;
        run_window(1'b0, 20, 13, 0, 5, 0, "R2 restart mid window");
    endtask

    task automatic t_scope();
        period_sel_i = 2'b00;
        scope_ext_i  = 1'b0;
        run_window(1'b1, 70, 0, 0, 0, 0, "R5 external unwatched");
        scope_ext_i  = 1'b1;
        run_window(1'b1, 12, 8, 0, 0, 0, "R5 external watched");
        run_window(1'b0, 12, 8, 0, 0, 0, "R5 internal with ext scope");
    endtask

    task automatic t_debug();
        period_sel_i = 2'b00;
        scope_ext_i  = 1'b1;
        dbg_mode_i   = 1'b1;
        run_window(1'b0, 20, 0, 0, 0, 0, "R6 debug at start");
        run_window(1'b0, 20, 0, 0, 0, 4, "R6 debug mid cycle");
    endtask

    task automatic t_split();
        period_sel_i = 2'b00;
        scope_ext_i  = 1'b1;
        run_window(1'b1, 20, 15, 6, 7, 0, "R7 split access second half");
    endtask

    task automatic t_idle();
        period_sel_i = 2'b00;
        run_window(1'b0, 80, 8, 30, 0, 0, "R8 idle after timeout");
    endtask

    task automatic t_reset_mid();
        int seen = 0;
        period_sel_i = 2'b00;
        cyc_ext_i    = 1'b0;
        cyc_start_i  = 1'b1;
        @(negedge clk);
        cyc_start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            seen |= bus_err_o;
        end
        check(seen == 0, "R9 reset mid cycle", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_periods();
        t_ack();
        t_restart();
        t_scope();
        t_debug();
        t_split();
        t_idle();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual 0 expected 1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule